// File: doc/BRIEF.md
# Palette Header Loader with Colour Lookup

This block fills a colour lookup table from a stream of 32-bit words and then serves indexed colour lookups. A load begins with a one-cycle start pulse. Each accepted word holds two 16-bit palette entries, the lower half first. The upper nibble of the very first entry is a pixel-depth code. That code decides how many words the load takes. The lower twelve bits of every entry are a 4:4:4 RGB colour that is written into the table.

Once the expected number of words has arrived, the block raises a one-cycle completion pulse and stops accepting data. Display logic can then present a pixel index and receive the 12-bit colour one cycle later. Indices outside the 256-entry table are flagged and read as zero.

Top module: `pal_hdr_loader`

## Requirements
- R1: The depth code is bits 15:12 of the low half of the first word of a load. It appears on `depth_code` in the cycle after that word is accepted. It then holds until the first word of the next load is accepted, whatever the upper nibbles of later entries hold.
- R2: Each entry carries its colour in bits 11:0: red in 11:8, green in 7:4 and blue in 3:0. A lookup returns these twelve bits unchanged on `rd_rgb`, with red in bits 11:8.
- R3: Word k of a load carries entry 2k in bits 15:0 and entry 2k+1 in bits 31:16.
- R4: Depth codes 0 to 3 (1, 2, 4 and 8 bits per pixel) select a 256-entry palette, and the load takes 129 words. Codes 4 and above (12 or 16 bits per pixel) select a 16-entry palette, and the load takes 9 words. Entries whose index is at or beyond the palette size are discarded, and the table keeps its previous contents there.
- R5: `load_done` is high for exactly one cycle, in the cycle after the last expected word is accepted. From that cycle `wr_ready` is low.
- R6: Outside a load `wr_ready` is low. Words offered there change neither the table nor `depth_code`.
- R7: The low twelve bits of entry 0, which also carries the depth code, are stored as colour index 0.
- R8: `rd_rgb` and `rd_bad` reflect the `rd_idx` of the previous cycle. An index above 255 gives `rd_bad` = 1 and `rd_rgb` = 0.
- R9: A start pulse during a load restarts the count at word 0. Entries already written by the abandoned load stay where the new load does not overwrite them.
- R10: After reset `wr_ready`, `load_done` and `depth_code` are zero, and every table entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_start | input | 1 | Begin (or restart) a palette load |
| wr_valid | input | 1 | Palette word offered |
| wr_data | input | 32 | Two palette entries, low half first |
| wr_ready | output | 1 | Block accepts palette words |
| load_done | output | 1 | One-cycle pulse after the last word |
| depth_code | output | 4 | Depth code decoded from entry 0 |
| rd_idx | input | 9 | Lookup index |
| rd_rgb | output | 12 | Looked-up 4:4:4 colour |
| rd_bad | output | 1 | Previous index was out of range |

## Verification
Every depth code from 0 to 4 is loaded, plus one code above 4. Each load uses its own arithmetic colour pattern, and all 512 lookup indices are swept after each load. This separates the long and short transfer lengths, the half-word order, and the retention of entries beyond a short palette. The upper nibbles of non-first entries are deliberately nonzero, so a depth decoder that listens to the wrong entry stands out. Words offered while idle, and a load abandoned halfway, show whether stray data reaches the table. Sweeping indices above 255 exercises the out-of-range flag.

// File: rtl/pal_hdr_loader.sv
module pal_hdr_loader #(
  parameter int IDX_W   = 9,
  parameter int LONG_N  = 256,
  parameter int SHORT_N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  output logic             wr_ready,
  output logic             load_done,
  output logic [3:0]       depth_code,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [11:0]      rd_rgb,
  output logic             rd_bad
);
  localparam int LONG_WORDS  = LONG_N * 2 / 4 + 1;
  localparam int SHORT_WORDS = SHORT_N * 2 / 4 + 1;
  localparam int CNT_W       = $clog2(LONG_WORDS);
  localparam int ENT_W       = CNT_W + 1;
  localparam int RAM_AW      = $clog2(LONG_N);

  logic             busy, done_q;
  logic [CNT_W-1:0] wcnt;
  logic [3:0]       code_q;
  logic [11:0]      ram [LONG_N];

  wire              take     = busy & wr_valid & ~load_start;
  wire  [3:0]       cur_code = (wcnt == '0) ? wr_data[15:12] : code_q;
  wire              is_long  = cur_code < 4'd4;
  wire  [CNT_W-1:0] last_cnt = is_long ? CNT_W'(LONG_WORDS - 1) : CNT_W'(SHORT_WORDS - 1);
  wire  [ENT_W:0]   limit    = is_long ? (ENT_W+1)'(LONG_N) : (ENT_W+1)'(SHORT_N);
  wire  [ENT_W-1:0] e_lo     = {wcnt, 1'b0};
  wire  [ENT_W-1:0] e_hi     = {wcnt, 1'b1};
  wire              is_last  = take && (wcnt == last_cnt);

  assign wr_ready   = busy;
  assign load_done  = done_q;
  assign depth_code = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done_q <= 1'b0;
      wcnt   <= '0;
      code_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_start) begin
        busy <= 1'b1;
        wcnt <= '0;
      end else if (take) begin
        if (wcnt == '0) code_q <= wr_data[15:12];
        if (is_last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
          wcnt   <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LONG_N; i++) ram[i] <= '0;
    end else if (take) begin
      if ({1'b0, e_lo} < limit) ram[e_lo[RAM_AW-1:0]] <= wr_data[11:0];
      if ({1'b0, e_hi} < limit) ram[e_hi[RAM_AW-1:0]] <= wr_data[27:16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_rgb <= '0;
      rd_bad <= 1'b0;
    end else begin
      rd_bad <= rd_idx >= IDX_W'(LONG_N);
      rd_rgb <= (rd_idx >= IDX_W'(LONG_N)) ? 12'h000 : ram[rd_idx[RAM_AW-1:0]];
    end
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done);
  assert_done_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !wr_ready);
  assert_idle_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> $stable(depth_code));
  assert_long_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CNT_W'(LONG_WORDS - 1));
  assert_short_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wcnt != '0 && code_q >= 4'd4) |-> (wcnt < CNT_W'(SHORT_WORDS)));
  assert_bad_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx >= IDX_W'(LONG_N)) |=> (rd_bad && rd_rgb == 12'h000));
endmodule

// File: tb/pal_hdr_loader_bench.sv
`timescale 1ns/1ps
module pal_hdr_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_start = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, load_done, rd_bad;
  logic [3:0]  depth_code;
  logic [8:0]  rd_idx = '0;
  logic [11:0] rd_rgb;

  int tests = 0;
  int fails = 0;
  logic [11:0] model [256];

  pal_hdr_loader u_pal_hdr_loader (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .load_done(load_done),
    .depth_code(depth_code), .rd_idx(rd_idx), .rd_rgb(rd_rgb), .rd_bad(rd_bad));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] colour(input int e, input int seed);
    return 12'((e * 29 + seed * 173 + 5) % 4096);
  endfunction

  task automatic sweep(input string req);
    for (int i = 0; i < 512; i++) begin
      @(negedge clk) rd_idx = 9'(i);
      @(negedge clk);
      if (i > 255) begin
        chk(rd_bad == 1'b1 && rd_rgb == 12'h000, "R8", {rd_bad, rd_rgb}, 32'h1000);
      end else begin
        chk(rd_bad == 1'b0 && rd_rgb == model[i], req, {rd_bad, rd_rgb}, model[i]);
      end
    end
  endtask

  task automatic do_load(input int code, input int seed, input int nsend);
    int full = (code < 4) ? 129 : 9;
    int lim  = (code < 4) ? 256 : 16;
    @(negedge clk) load_start = 1'b1;
    @(negedge clk) load_start = 1'b0;
    for (int k = 0; k < nsend; k++) begin
      if (k == 1) chk(depth_code == 4'(code), "R1", depth_code, code);
      chk(wr_ready == 1'b1, "R6", wr_ready, 1);
      if (k > 0) chk(load_done == 1'b0, "R5", load_done, 0);
      wr_valid = 1'b1;
      wr_data  = {4'h5, colour(2*k+1, seed), (k == 0) ? 4'(code) : 4'h5, colour(2*k, seed)};
      if (2*k < lim)   model[2*k]   = colour(2*k, seed);
      if (2*k+1 < lim) model[2*k+1] = colour(2*k+1, seed);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    if (nsend == full) begin
      chk(load_done == 1'b1, "R5", load_done, 1);
      chk(wr_ready == 1'b0, "R5", wr_ready, 0);
      chk(depth_code == 4'(code), "R1", depth_code, code);
      @(negedge clk);
      chk(load_done == 1'b0, "R5", load_done, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1'b0, "R10", wr_ready, 0);
    chk(load_done == 1'b0, "R10", load_done, 0);
    chk(depth_code == 4'h0, "R10", depth_code, 0);
    sweep("R10");

    do_load(3, 1, 129);
    chk(model[0] == colour(0, 1), "R7", model[0], colour(0, 1));
    sweep("R3");
    do_load(0, 2, 129);
    sweep("R2");
    do_load(1, 3, 129);
    sweep("R3");
    do_load(4, 4, 9);
    sweep("R4");
    do_load(2, 5, 129);
    sweep("R7");
    do_load(7, 6, 9);
    sweep("R4");

    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(wr_ready == 1'b0, "R6", wr_ready, 0);
      wr_valid = 1'b1;
      wr_data  = 32'hFFFF_FFFF;
    end
    @(negedge clk) wr_valid = 1'b0;
    chk(load_done == 1'b0, "R6", load_done, 0);
    chk(depth_code == 4'h7, "R6", depth_code, 7);
    sweep("R6");

    do_load(2, 9, 20);
    do_load(4, 11, 9);
    chk(depth_code == 4'h4, "R9", depth_code, 4);
    sweep("R9");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule